// File: doc/BRIEF.md
# Sequential Byte Log Pointer Sequencer

This block sits between a host and a DRAM strobe controller and makes the DRAM behave as an append-only byte log. It holds two independent pointers. The write pointer is the append position and the read pointer is the consume position. Each pointer is split into the row and column fields that a multiplexed-address DRAM expects. The host issues single-cycle commands: append a byte, consume a byte, read or write one explicit address, zero-fill the memory, or replay the whole log. The block turns each command into one or more requests to the controller and returns read bytes on a one-cycle output strobe.

A pointer is made of two low fields of `FIELD_W` bits each (8 by default) and an 8-bit top field. The low fields feed the row and the column directly. The top field is split bit by bit between them, so that the row and column widths grow together. The installed module size is chosen by `SIZE_SEL`. The size sets which pointer bit counts as overflow, and that bit also marks where the zero-fill stops.

Top module: `logseq_top`

## Requirements
- R1: After reset, `cmd_ready` is 1, and `mem_req`, `rd_valid`, `wr_ovf` and `rd_ovf` are 0. Both pointers are zero.
- R2: For a pointer or explicit address P with top field T = P[2F+7:2F], where F = FIELD_W, the row is {T[6],T[4],T[2],T[0],P[F-1:0]} and the column is {T[7],T[5],T[3],T[1],P[2F-1:F]}.
- R3: Append (`cmd_op`=0) writes `cmd_data` at the write pointer and then adds one to it. The lowest field counts first and carries into the next field only when it wraps to zero.
- R4: Consume (`cmd_op`=1) reads at the read pointer and then adds one to it. The two pointers never affect each other. A read byte appears on `rd_data` with `rd_valid` high for one cycle, in the cycle after the controller's `mem_ack`.
- R5: Explicit write (`cmd_op`=2) and explicit read (`cmd_op`=3) use `cmd_addr` with the mapping of R2, and leave both pointers unchanged.
- R6: A request holds `mem_req`, `mem_we`, `mem_row` and `mem_col` steady from its first cycle until the cycle in which `mem_ack` is seen.
- R7: `wr_ovf` (or `rd_ovf`) is high while bit 2F+2+2·SIZE_SEL of the write (or read) count is set. SIZE_SEL 0, 1 and 2 select top-field bits 2, 4 and 6. SIZE_SEL 3 selects the carry out of the top field.
- R8: Zero-fill (`cmd_op`=4) resets the write pointer and writes 0 at every address until the R7 overflow condition appears. It then resets both pointers to zero.
- R9: Replay (`cmd_op`=5) resets the read pointer and consumes bytes in address order until all three fields of the read pointer equal those of the write pointer.
- R10: Replay with the write pointer at zero produces no request and no output byte.
- R11: `cmd_op` values 6 and 7 are ignored: no request, no output, and no pointer change.
- R12: `cmd_ready` is low while any request is outstanding. Commands are taken only while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when `cmd_ready` is high |
| cmd_op | input | 3 | Command code (see R3–R11) |
| cmd_addr | input | 2·FIELD_W+8 | Explicit address for read and write commands |
| cmd_data | input | DATA_W | Byte for append and explicit write |
| cmd_ready | output | 1 | Block idle, can take a command |
| mem_req | output | 1 | Request to the controller, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_row | output | FIELD_W+4 | Row address field |
| mem_col | output | FIELD_W+4 | Column address field |
| mem_wdata | output | DATA_W | Write byte |
| mem_ack | input | 1 | Controller completion, one cycle |
| mem_rdata | input | DATA_W | Read byte, valid with `mem_ack` |
| rd_valid | output | 1 | Output byte strobe |
| rd_data | output | DATA_W | Output byte |
| wr_ovf | output | 1 | Write pointer at or past the size boundary |
| rd_ovf | output | 1 | Read pointer at or past the size boundary |

## Verification
Appends, consumes and explicit accesses are interleaved in a fixed table. This shows that the two pointers stay independent and that explicit accesses do not move either of them. An address with every top-field bit pattern distinct (0xA5F0) separates the row half of the interleave from the column half. A long append run crosses the low-field carry and reaches the 256K-class boundary one step after the last clear count. Zero-fill, replay of a filled log and replay of an empty log each show their stop conditions through the number and the addresses of the requests they issue.

// File: rtl/logseq_pkg.sv
package logseq_pkg;

   typedef enum logic [2:0] {
      OP_APPEND  = 3'd0,
      OP_CONSUME = 3'd1,
      OP_WR_AT   = 3'd2,
      OP_RD_AT   = 3'd3,
      OP_ZFILL   = 3'd4,
      OP_REPLAY  = 3'd5
   } log_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ACCESS,
      ST_ZFILL,
      ST_REPLAY
   } seq_state_e;

   // Pointer bit that marks the module-size boundary
   function automatic int ovf_index(input int field_w, input int size_sel);
      return 2 * field_w + 2 + 2 * size_sel;
   endfunction

endpackage

// File: rtl/logseq_ptr.sv
module logseq_ptr #(
   parameter int PTR_W   = 24,
   parameter int OVF_IDX = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [PTR_W-1:0] ptr,
   output logic             ovf
);
   // One extra bit holds the carry out of the top field
   logic [PTR_W:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (inc)  cnt_q <= cnt_q + 1'b1;
   end

   assign ptr = cnt_q[PTR_W-1:0];
   assign ovf = cnt_q[OVF_IDX];
endmodule

// File: rtl/logseq_map.sv
module logseq_map #(
   parameter int FIELD_W = 8,
   parameter int TOP_W   = 8,
   localparam int PTR_W  = 2 * FIELD_W + TOP_W,
   localparam int LINE_W = FIELD_W + TOP_W / 2
) (
   input  logic [PTR_W-1:0]  ptr,
   output logic [LINE_W-1:0] row,
   output logic [LINE_W-1:0] col
);
   logic [TOP_W-1:0] top;
   assign top = ptr[PTR_W-1:2*FIELD_W];

   assign row[FIELD_W-1:0] = ptr[FIELD_W-1:0];
   assign col[FIELD_W-1:0] = ptr[2*FIELD_W-1:FIELD_W];

   for (genvar i = 0; i < TOP_W / 2; i++) begin : g_split
      assign row[FIELD_W+i] = top[2*i];
      assign col[FIELD_W+i] = top[2*i+1];
   end
endmodule

// File: rtl/logseq_top.sv
module logseq_top
   import logseq_pkg::*;
#(
   parameter int FIELD_W  = 8,
   parameter int DATA_W   = 8,
   parameter int SIZE_SEL = 1,
   localparam int PTR_W   = 2 * FIELD_W + 8,
   localparam int LINE_W  = FIELD_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [PTR_W-1:0]  cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   output logic              cmd_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [LINE_W-1:0] mem_row,
   output logic [LINE_W-1:0] mem_col,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              wr_ovf,
   output logic              rd_ovf
);
   localparam int OVF_IDX = ovf_index(FIELD_W, SIZE_SEL);

   if (FIELD_W < 2) begin : g_bad_field
      $error("logseq_top: FIELD_W must be at least 2");
   end
   if (SIZE_SEL < 0 || SIZE_SEL > 3) begin : g_bad_size
      $error("logseq_top: SIZE_SEL must be 0..3");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("logseq_top: DATA_W must be positive");
   end

   seq_state_e          state_q;
   log_op_e             op_q;
   logic [PTR_W-1:0]    addr_q;
   logic [DATA_W-1:0]   wdata_q;

   logic [PTR_W-1:0]    wp, rp, sel_ptr;
   logic                wp_clr, wp_inc, rp_clr, rp_inc;
   logic                take, op_ok, ack_now;
   logic                on_wp, on_rp;

   assign cmd_ready = (state_q == ST_IDLE);
   assign take      = cmd_valid && cmd_ready;
   assign op_ok     = (cmd_op <= 3'd5);
   assign mem_req   = (state_q == ST_ACCESS);
   assign ack_now   = mem_req && mem_ack;

   assign on_wp   = (op_q == OP_APPEND)  || (op_q == OP_ZFILL);
   assign on_rp   = (op_q == OP_CONSUME) || (op_q == OP_REPLAY);
   assign mem_we  = on_wp || (op_q == OP_WR_AT);
   assign mem_wdata = (op_q == OP_ZFILL) ? '0 : wdata_q;
   assign sel_ptr = on_wp ? wp : (on_rp ? rp : addr_q);

   assign wp_inc = ack_now && on_wp;
   assign rp_inc = ack_now && on_rp;
   assign wp_clr = (take && op_ok && log_op_e'(cmd_op) == OP_ZFILL)
                || (state_q == ST_ZFILL && wr_ovf);
   assign rp_clr = (take && op_ok && log_op_e'(cmd_op) == OP_REPLAY)
                || (state_q == ST_ZFILL && wr_ovf);

   logseq_ptr #(.PTR_W(PTR_W), .OVF_IDX(OVF_IDX)) u_wptr (
      .clk(clk), .rst_n(rst_n), .clr(wp_clr), .inc(wp_inc), .ptr(wp), .ovf(wr_ovf)
   );
   logseq_ptr #(.PTR_W(PTR_W), .OVF_IDX(OVF_IDX)) u_rptr (
      .clk(clk), .rst_n(rst_n), .clr(rp_clr), .inc(rp_inc), .ptr(rp), .ovf(rd_ovf)
   );
   logseq_map #(.FIELD_W(FIELD_W), .TOP_W(8)) u_map (
      .ptr(sel_ptr), .row(mem_row), .col(mem_col)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_APPEND;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (take && op_ok) begin
               op_q    <= log_op_e'(cmd_op);
               addr_q  <= cmd_addr;
               wdata_q <= cmd_data;
               case (log_op_e'(cmd_op))
                  OP_ZFILL:  state_q <= ST_ZFILL;
                  OP_REPLAY: state_q <= ST_REPLAY;
                  default:   state_q <= ST_ACCESS;
               endcase
            end
            ST_ACCESS: if (mem_ack) begin
               if (op_q == OP_ZFILL)       state_q <= ST_ZFILL;
               else if (op_q == OP_REPLAY) state_q <= ST_REPLAY;
               else                        state_q <= ST_IDLE;
            end
            ST_ZFILL:  state_q <= wr_ovf ? ST_IDLE : ST_ACCESS;
            ST_REPLAY: state_q <= (rp == wp) ? ST_IDLE : ST_ACCESS;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= ack_now && !mem_we;
         if (ack_now && !mem_we) rd_data <= mem_rdata;
      end
   end
endmodule

// File: rtl/logseq_chk.sv
module logseq_chk #(
   parameter int LINE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_ready,
   input logic              mem_req,
   input logic              mem_ack,
   input logic              mem_we,
   input logic [LINE_W-1:0] mem_row,
   input logic [LINE_W-1:0] mem_col,
   input logic              rd_valid,
   input logic              wr_ovf,
   input logic              rd_ovf
);
   assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)
                                 && $stable(mem_row) && $stable(mem_col)));

   assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cmd_ready);

   assert_rd_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(mem_req && mem_ack && !mem_we));

   assert_wr_ovf_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_ovf) |-> $past(mem_req && mem_ack && mem_we));

   assert_rd_ovf_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_ovf) |-> $past(mem_req && mem_ack && !mem_we));
endmodule

bind logseq_top logseq_chk #(.LINE_W(LINE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .mem_req(mem_req),
   .mem_ack(mem_ack), .mem_we(mem_we), .mem_row(mem_row), .mem_col(mem_col),
   .rd_valid(rd_valid), .wr_ovf(wr_ovf), .rd_ovf(rd_ovf)
);

// File: tb/logseq_top_tb_top.sv
`timescale 1ns/1ps
module logseq_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [15:0] cmd_addr = '0;
   logic [7:0]  cmd_data = '0;
   logic        cmd_ready, mem_req, mem_we, rd_valid, wr_ovf, rd_ovf;
   logic [7:0]  mem_row, mem_col, mem_wdata, rd_data;
   logic        mem_ack = 1'b0;
   logic [7:0]  mem_rdata = '0;

   always #2.5 clk = ~clk;

   logseq_top #(.FIELD_W(4), .DATA_W(8), .SIZE_SEL(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_row(mem_row), .mem_col(mem_col),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .wr_ovf(wr_ovf), .rd_ovf(rd_ovf)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   int unsigned req_cnt = 0;
   int unsigned zero_wr_cnt = 0;
   int unsigned busy_viol = 0;
   logic [15:0] last_rc = '0;
   logic        last_we = 1'b0;
   logic [7:0]  last_wd = '0;
   logic [7:0]  mem_model [logic [15:0]];
   logic [7:0]  outq [$];

   // Row/column pair {row,col} expected for a 16-bit pointer (F = 4)
   function automatic logic [15:0] rc_of(input logic [15:0] a);
      logic [7:0] r, c;
      r = {a[14], a[12], a[10], a[8], a[3:0]};
      c = {a[15], a[13], a[11], a[9], a[7:4]};
      return {r, c};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Controller model: acknowledges one cycle after a request is seen
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
      end else begin
         if (mem_ack) mem_ack <= 1'b0;
         else if (mem_req) begin
            req_cnt++;
            last_rc = {mem_row, mem_col};
            last_we = mem_we;
            last_wd = mem_wdata;
            if (mem_we) begin
               mem_model[{mem_row, mem_col}] = mem_wdata;
               if (mem_wdata == 8'h00) zero_wr_cnt++;
            end else begin
               mem_rdata <= mem_model.exists({mem_row, mem_col}) ?
                            mem_model[{mem_row, mem_col}] : 8'h00;
            end
            mem_ack <= 1'b1;
         end
         if (rd_valid) outq.push_back(rd_data);
         if (mem_req && cmd_ready) busy_viol++;
      end
   end

   task automatic do_cmd(input logic [2:0] op, input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
   endtask

   // {op, addr, data, expected read byte, expected access address}
   localparam logic [50:0] VEC [12] = '{
      {3'd0, 16'h0000, 8'h11, 8'h00, 16'h0000},
      {3'd0, 16'h0000, 8'h22, 8'h00, 16'h0001},
      {3'd2, 16'h0123, 8'h5A, 8'h00, 16'h0123},
      {3'd0, 16'h0000, 8'h33, 8'h00, 16'h0002},
      {3'd1, 16'h0000, 8'h00, 8'h11, 16'h0000},
      {3'd3, 16'h0123, 8'h00, 8'h5A, 16'h0123},
      {3'd1, 16'h0000, 8'h00, 8'h22, 16'h0001},
      {3'd2, 16'hA5F0, 8'h77, 8'h00, 16'hA5F0},
      {3'd3, 16'hA5F0, 8'h00, 8'h77, 16'hA5F0},
      {3'd7, 16'h0000, 8'h00, 8'h00, 16'h0000},
      {3'd6, 16'h0042, 8'h99, 8'h00, 16'h0000},
      {3'd0, 16'h0000, 8'h44, 8'h00, 16'h0003}
   };

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=0x0 expected=0x1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int unsigned rc0, z0;
      int mism;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(cmd_ready && !mem_req && !rd_valid && !wr_ovf && !rd_ovf, "R1 reset",
            {cmd_ready, mem_req, rd_valid, wr_ovf, rd_ovf}, 5'b10000);

      // Table walk: R2 mapping, R3 append, R4 consume, R5 explicit, R11 ignored codes
      for (int i = 0; i < 12; i++) begin
         logic [2:0] op; logic [15:0] a, ea; logic [7:0] d, er;
         op = VEC[i][50:48]; a = VEC[i][47:32]; d = VEC[i][31:24];
         er = VEC[i][23:16]; ea = VEC[i][15:0];
         rc0 = req_cnt; outq.delete();
         do_cmd(op, a, d);
         if (op > 3'd5) begin
            check(req_cnt == rc0 && outq.size() == 0, "R11 ignored code",
                  req_cnt - rc0 + outq.size(), 0);
         end else begin
            check(req_cnt == rc0 + 1, "R12 one request", req_cnt - rc0, 1);
            check(last_rc == rc_of(ea), "R2 address mapping", last_rc, rc_of(ea));
            if (op == 3'd0 || op == 3'd2) begin
               check(last_we && last_wd == d, op == 3'd0 ? "R3 append write" : "R5 explicit write",
                     {last_we, last_wd}, {1'b1, d});
            end else begin
               check(!last_we && outq.size() == 1 && outq[0] == er,
                     op == 3'd1 ? "R4 consume data" : "R5 explicit read",
                     outq.size() == 1 ? outq[0] : 9'h1FF, er);
            end
         end
      end

      // R9 replay of a four-byte log
      rc0 = req_cnt; outq.delete();
      do_cmd(3'd5, 16'h0, 8'h0);
      check(req_cnt - rc0 == 4, "R9 replay request count", req_cnt - rc0, 4);
      check(outq.size() == 4 && outq[0] == 8'h11 && outq[1] == 8'h22 &&
            outq[2] == 8'h33 && outq[3] == 8'h44, "R9 replay order",
            outq.size() == 4 ? {outq[0], outq[1], outq[2], outq[3]} : 0, 32'h11223344);
      do_cmd(3'd1, 16'h0, 8'h0);
      check(last_rc == rc_of(16'h0004), "R9 read pointer ends at write pointer",
            last_rc, rc_of(16'h0004));

      // R8 zero-fill
      rc0 = req_cnt; z0 = zero_wr_cnt;
      do_cmd(3'd4, 16'h0, 8'h0);
      check(req_cnt - rc0 == 1024 && zero_wr_cnt - z0 == 1024, "R8 zero-fill writes",
            req_cnt - rc0, 1024);
      check(last_we && last_rc == rc_of(16'h03FF), "R8 zero-fill last address",
            last_rc, rc_of(16'h03FF));
      check(!wr_ovf && !rd_ovf, "R8 flags low after zero-fill", {wr_ovf, rd_ovf}, 0);
      outq.delete();
      do_cmd(3'd3, 16'h0123, 8'h0);
      check(outq.size() == 1 && outq[0] == 8'h00, "R8 old byte zeroed",
            outq.size() == 1 ? outq[0] : 9'h1FF, 0);

      // R10 empty replay
      rc0 = req_cnt; outq.delete();
      do_cmd(3'd5, 16'h0, 8'h0);
      check(req_cnt == rc0 && outq.size() == 0, "R10 empty replay",
            req_cnt - rc0 + outq.size(), 0);
      do_cmd(3'd1, 16'h0, 8'h0);
      check(last_rc == rc_of(16'h0000), "R8 read pointer reset", last_rc, rc_of(16'h0000));

      // R3 carry and R7 write boundary (256K class: bit 10 at F = 4)
      mism = 0;
      for (int i = 0; i < 1024; i++) begin
         do_cmd(3'd0, 16'h0, 8'(i));
         if (last_rc != rc_of(16'(i))) mism++;
         if (i == 1022) check(!wr_ovf, "R7 write flag before boundary", wr_ovf, 0);
      end
      check(mism == 0, "R3 append sequence with carries", mism, 0);
      check(wr_ovf, "R7 write flag at boundary", wr_ovf, 1);

      // R4 independent consume and R7 read boundary
      mism = 0; outq.delete();
      for (int i = 1; i < 1024; i++) begin
         do_cmd(3'd1, 16'h0, 8'h0);
         if (i == 1022) check(!rd_ovf, "R7 read flag before boundary", rd_ovf, 0);
      end
      for (int i = 1; i < 1024; i++)
         if (outq.size() != 1023 || outq[i-1] != 8'(i)) mism++;
      check(mism == 0, "R4 consume stream", mism, 0);
      check(rd_ovf, "R7 read flag at boundary", rd_ovf, 1);

      check(busy_viol == 0, "R12 ready low while requesting", busy_viol, 0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule